// File: doc/BRIEF.md
# Dual-Channel Watchdog Timer

This block supervises software with two independent up-counting watchdog channels. A shared prescaler divides the system clock into a single-cycle tick. Each tick stands for 10 ms of elapsed time. On every tick, each enabled channel advances its 15-bit count toward a 15-bit limit that software programs.

Software keeps a channel alive by writing its register. Any such write loads a new limit and action bit and clears the count in the same cycle. When a count reaches its limit, the channel is expired and stays so until the next write.

The two channels act differently on expiry:
- Channel 0 raises a system reset request when its action bit is set.
- Channel 1, when its enable bit is set, raises an indication that CPU-bound traffic is to be dropped and flow control turned off on all ports.

Top module: `wdt_top`

## Requirements
- R1: After reset, both channel registers read as zero, and `rst_req` and `drop_req` are low.
- R2: Channel 0 sits at address 0xC0 and channel 1 at 0xC4. A read returns {action bit[31], limit[30:16], 0 at bit 15, count[14:0]}. Any other address reads as zero.
- R3: A write to a channel address does three things in the same clock: it loads the limit from wr_data[30:16], loads the action bit from wr_data[31], and clears the count. Write data in bits 15:0 is ignored.
- R4: The tick fires once every CLKS_PER_TICK clocks. The first tick comes CLKS_PER_TICK clocks after reset is released. On a tick, a channel with a nonzero limit and count below that limit increments its count by exactly one.
- R5: A count never exceeds its nonzero limit. On reaching the limit, the count holds there until the channel is written.
- R6: With a limit of zero, the count stays at zero and the channel never expires.
- R7: `rst_req` is high exactly when channel 0 has its action bit set and its count equals its nonzero limit. It stays high until channel 0 is written.
- R8: `drop_req` is high exactly when channel 1 has its enable bit set and its count equals its nonzero limit. It stays high until channel 1 is written.
- R9: A write to one channel leaves the other channel unchanged. A write to any other address changes neither channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Register address, shared by reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | Channel 0 expiry with reset action enabled |
| drop_req | output | 1 | Channel 1 expiry: drop CPU-bound traffic and disable flow control |

## Verification
A prescaler phase error moves every count change by whole clocks. Such an error shows up in the readback one tick period after reset at the latest, because the bench compares both registers on every cycle.

A corrupted count or limit appears in `rd_data` immediately. It also moves the `rst_req` or `drop_req` edge by whole ticks.

A write that leaks into the wrong channel changes the other register's readback in the very next cycle. A count that ignores the zero-limit rule or passes its limit shows up after one further tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W  = 32;
    localparam int CNT_W   = 15;
    localparam int NUM_CH  = 2;
    localparam int BASE_OFS = 8'hC0;
    localparam int CH_STRIDE = 4;

    // state held by one watchdog channel
    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] cnt;
    } wdt_chan_t;

    // byte address of a channel register
    function automatic int chan_offset(input int idx);
        return BASE_OFS + CH_STRIDE * idx;
    endfunction

    // readback word: action, limit, zero hole, count
    function automatic logic [DATA_W-1:0] pack_reg(input wdt_chan_t s);
        return {s.act, s.lim, 1'b0, s.cnt};
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int CLKS_PER_TICK = 1250000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);

    logic [PW-1:0] phase;

    assign tick = (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end
endmodule

// File: rtl/wdt_decode.sv
module wdt_decode
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] wr_sel
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(chan_offset(i));
        assign hit[i]    = (addr == OFS);
        assign wr_sel[i] = wr_en & hit[i];
    end
endmodule

// File: rtl/wdt_channel.sv
module wdt_channel
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    output wdt_chan_t         st,
    output logic              expired
);
    logic armed;
    logic at_lim;

    assign armed   = (st.lim != '0);
    assign at_lim  = (st.cnt == st.lim);
    assign expired = armed & at_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr) begin
            st.act <= wr_data[31];
            st.lim <= wr_data[30:16];
            st.cnt <= '0;
        end else if (tick && armed && !at_lim) begin
            st.cnt <= st.cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CLKS_PER_TICK = 1250000,
    parameter int ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              rst_req,
    output logic              drop_req
);
    logic                   tick;
    logic [NUM_CH-1:0]      hit;
    logic [NUM_CH-1:0]      wr_sel;
    logic [NUM_CH-1:0]      expired;
    wdt_chan_t [NUM_CH-1:0] chan_st;

    wdt_prescaler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    wdt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .hit   (hit),
        .wr_sel(wr_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        wdt_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .wr     (wr_sel[i]),
            .wr_data(wr_data),
            .st     (chan_st[i]),
            .expired(expired[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i]) rd_data = pack_reg(chan_st[i]);
        end
    end

    assign rst_req  = chan_st[0].act & expired[0];
    assign drop_req = chan_st[1].act & expired[1];
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CH-1:0]      wr_sel,
    input wdt_chan_t [NUM_CH-1:0] chan_st,
    input logic                   rst_req,
    input logic                   drop_req
);
    // R5: count bounded by a nonzero limit
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (chan_st[0].lim != '0) |-> (chan_st[0].cnt <= chan_st[0].lim));
    assert_cnt_bound1_R5: assert property (@(posedge clk) disable iff (rst)
        (chan_st[1].lim != '0) |-> (chan_st[1].cnt <= chan_st[1].lim));

    // R6: zero limit keeps the count at zero and outputs quiet
    assert_zero_lim_R6: assert property (@(posedge clk) disable iff (rst)
        (chan_st[0].lim == '0) |-> (chan_st[0].cnt == '0 && !rst_req));
    assert_zero_lim1_R6: assert property (@(posedge clk) disable iff (rst)
        (chan_st[1].lim == '0) |-> (chan_st[1].cnt == '0 && !drop_req));

    // R3: a write clears the count
    assert_wr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        wr_sel[0] |=> (chan_st[0].cnt == '0));

    // R4: without a write the count holds or steps by one
    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_sel[0] |=> (chan_st[0].cnt == $past(chan_st[0].cnt) ||
                        chan_st[0].cnt == CNT_W'($past(chan_st[0].cnt) + 1'b1)));

    // R9: a write to channel 0 leaves channel 1 intact
    assert_isolate_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_sel[0] && !wr_sel[1]) |=> (chan_st[1].lim == $past(chan_st[1].lim) &&
                                       chan_st[1].act == $past(chan_st[1].act)));

    // R7: reset request is sticky until channel 0 is written
    assert_rst_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rst_req && !wr_sel[0]) |=> rst_req);

    // R8: drop indication is sticky and requires the enable bit
    assert_drop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (drop_req && !wr_sel[1]) |=> drop_req);
    assert_drop_en_R8: assert property (@(posedge clk) disable iff (rst)
        drop_req |-> chan_st[1].act);
endmodule

bind wdt_top wdt_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_sel  (wr_sel),
    .chan_st (chan_st),
    .rst_req (rst_req),
    .drop_req(drop_req)
);

// File: tb/wdt_top_bench.sv
module wdt_top_bench;
    localparam int N    = 4;
    localparam int AW   = 8;
    localparam logic [AW-1:0] A0 = 8'hC0;
    localparam logic [AW-1:0] A1 = 8'hC4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          rst_req;
    logic          drop_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    wdt_top #(.CLKS_PER_TICK(N), .ADDR_W(AW)) u_wdt_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .rst_req(rst_req), .drop_req(drop_req)
    );

    // reference model built from the requirements
    int          m_pre;
    logic [14:0] m_lim [2];
    logic [14:0] m_cnt [2];
    logic        m_act [2];

    always @(posedge clk) begin
        if (rst) begin
            m_pre <= 0;
            for (int i = 0; i < 2; i++) begin
                m_lim[i] <= '0; m_cnt[i] <= '0; m_act[i] <= 1'b0;
            end
        end else begin
            m_pre <= (m_pre == N - 1) ? 0 : m_pre + 1;
            for (int i = 0; i < 2; i++) begin
                if (wr_en && addr == (i == 0 ? A0 : A1)) begin
                    m_act[i] <= wr_data[31];
                    m_lim[i] <= wr_data[30:16];
                    m_cnt[i] <= '0;
                end else if (m_pre == N - 1 && m_lim[i] != 0 && m_cnt[i] != m_lim[i]) begin
                    m_cnt[i] <= m_cnt[i] + 1'b1;
                end
            end
        end
    end

    function automatic logic [31:0] exp_reg(input int i);
        return {m_act[i], m_lim[i], 1'b0, m_cnt[i]};
    endfunction

    function automatic logic exp_out(input int i);
        return m_act[i] && m_lim[i] != 0 && m_cnt[i] == m_lim[i];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    // compare both registers and both outputs against the model (R4 R5 R7 R8)
    task automatic cyc_check();
        logic [31:0] d;
        rd(A0, d); chk("R4/R5 ch0", d, exp_reg(0));
        rd(A1, d); chk("R4/R5 ch1", d, exp_reg(1));
        chk("R7 rst_req", 32'(rst_req), 32'(exp_out(0)));
        chk("R8 drop_req", 32'(drop_req), 32'(exp_out(1)));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cyc_check();
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A0, d); chk("R1 ch0 reset", d, 32'h0);
        rd(A1, d); chk("R1 ch1 reset", d, 32'h0);
        chk("R1 rst_req", 32'(rst_req), 32'h0);
        chk("R1 drop_req", 32'(drop_req), 32'h0);
        rd(8'h00, d); chk("R2 unmapped read", d, 32'h0);

        // R3 load, clear, bit 15 ignored
        wr(A0, 32'h8003_FFFF);
        rd(A0, d); chk("R3 ch0 load", d, 32'h8003_0000);
        // R4 R5 R7 count to limit and hold
        idle(4 * N + 6);
        rd(A0, d); chk("R5 ch0 saturated", d, 32'h8003_0003);
        chk("R7 rst_req asserted", 32'(rst_req), 32'h1);

        // R8 with R9 isolation
        wr(A1, 32'h8002_0000);
        rd(A0, d); chk("R9 ch0 untouched", d, 32'h8003_0003);
        idle(3 * N + 4);
        chk("R8 drop_req asserted", 32'(drop_req), 32'h1);
        chk("R7 rst_req still held", 32'(rst_req), 32'h1);

        // R6 zero limit never counts
        wr(A0, 32'h8000_0000);
        idle(5 * N);
        rd(A0, d); chk("R6 zero limit", d, 32'h8000_0000);
        chk("R6 no rst_req", 32'(rst_req), 32'h0);

        // R9 unmapped write
        wr(8'h10, 32'hFFFF_FFFF);
        rd(A1, d); chk("R9 ch1 after stray write", d, 32'h8002_0002);
        rd(8'h10, d); chk("R2 unmapped after write", d, 32'h0);

        // R7 action clear: expires silently
        wr(A0, 32'h0001_0000);
        idle(2 * N + 2);
        rd(A0, d); chk("R7 ch0 expired count", d, 32'h0001_0001);
        chk("R7 no request without action", 32'(rst_req), 32'h0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [31:0] wd;
            wd = $urandom;
            wd[30:16] = 15'($urandom_range(0, 7));
            wr(($urandom_range(0, 4) == 0) ? 8'h20 : (($urandom_range(0, 1) == 0) ? A0 : A1), wd);
            cyc_check();
            idle($urandom_range(0, 40));
        end

        done = 1;
        finish_run();
    end
endmodule